// File: doc/BRIEF.md
# Serial Card Host Register Interface

This block is the host-facing register decoder of a serial interface card that occupies one peripheral slot. The host selects the card with an active-low slot enable, gives a four-bit register offset, and issues active-low read or write strobes on an 8-bit data bus. The block turns each access into a single-cycle strobe toward an attached USART core. Reads return received data or status. Writes deliver transmit data, a control byte or a baud-rate value. A four-bit interrupt mask is held inside the block.

A separate active-low identification request lets the host probe the slot. While it is low, a read returns a fixed card code whether or not the slot enable is asserted. The interrupt request is the registered OR of four USART conditions, each gated by its own mask bit.

All inputs are sampled on the rising clock edge. An access is recognised once, on the first edge at which its strobe is seen low. The strobe outputs and captured write data appear one clock later.

Top module: `sercard_hostif`

## Requirements
- R1: A read at offset 0 with the slot enabled drives `usartRxData` onto `hostDataOut` with `hostDataOe` high, and pulses `usartRxTake` for one cycle, one clock after the read is first seen.
- R2: A read at offset 1 with the slot enabled drives `usartStatus` and pulses `usartStatTake` for one cycle, one clock after the read is first seen.
- R3: A write at offset 0 pulses `usartTxLoad` for one cycle, one clock after the write is first seen, with the written byte on `wrDataOut`.
- R4: A write at offset 1 pulses `usartCtrlLoad` for one cycle, with the written byte on `wrDataOut`.
- R5: A write at offset 8 or 9 pulses `baudLoad` for one cycle, with the written byte on `wrDataOut`.
- R6: A write at offset 0xA or 0xB loads data bits 3:0 into the interrupt mask and produces no USART strobe. Mask bit 3 gates `txEmpty`, bit 2 `txReady`, bit 1 `rxReady` and bit 0 `syncDet`.
- R7: With the slot enable high and the identification request high:
  - no strobe is produced;
  - the mask is unchanged;
  - `hostDataOe` stays low.
- R8: While `idReqN` is low, a read drives 0xF7 with `hostDataOe` high, regardless of the slot enable and the offset, and produces no USART read strobe.
- R9: `irqReq` equals the OR over the four bits of (mask AND condition), registered once. A change of condition or mask reaches `irqReq` one clock later.
- R10: Reset clears the mask, `irqReq` and every strobe output to zero.
- R11: A slot read at any offset other than 0 or 1 returns 0xFF.
- R12: An access held low for several cycles produces exactly one strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotSelN | input | 1 | Active-low slot enable |
| idReqN | input | 1 | Active-low identification request |
| rdN | input | 1 | Active-low host read strobe |
| wrN | input | 1 | Active-low host write strobe |
| addrLo | input | 4 | Register offset within the slot |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data (0xFF when not driving) |
| hostDataOe | output | 1 | Read data drive enable |
| usartRxData | input | 8 | Received byte from the USART |
| usartStatus | input | 8 | Status byte from the USART |
| txEmpty | input | 1 | USART transmitter empty |
| txReady | input | 1 | USART transmitter ready |
| rxReady | input | 1 | USART receiver ready |
| syncDet | input | 1 | USART sync detected |
| usartRxTake | output | 1 | Received byte consumed |
| usartStatTake | output | 1 | Status byte read |
| usartTxLoad | output | 1 | Transmit byte strobe |
| usartCtrlLoad | output | 1 | Control byte strobe |
| baudLoad | output | 1 | Baud-rate register load strobe |
| wrDataOut | output | 8 | Captured write byte for the strobes |
| irqReq | output | 1 | Masked interrupt request |

## Verification
The assertions check on every cycle the properties that hold in any state:
- at most one strobe is high at a time, and none lasts two cycles;
- no strobe follows a cycle with the slot deselected;
- the identification code is driven whenever it is requested;
- the read bus stays quiet when nothing selects it;
- the interrupt stays low one cycle after all conditions were false.

Only the bench scenarios can show the rest:
- the offset-to-target mapping and the exact read values;
- which mask bit gates which condition;
- that mask writes ignore the upper data bits;
- that a deselected write leaves the mask untouched.

// File: rtl/sercard_pkg.sv
package sercard_pkg;

  // Number of USART conditions that can raise the interrupt
  localparam int COND_N = 4;

  // Start-of-access strobes issued by the control to the datapath
  typedef struct packed {
    logic rxTake;
    logic statTake;
    logic txLoad;
    logic ctrlLoad;
    logic baudLoad;
    logic maskLoad;
  } hostStrb_t;

  // Read multiplexer selection
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_ID   = 2'd1,
    RSEL_RX   = 2'd2,
    RSEL_STAT = 2'd3
  } rdSel_t;

endpackage

// File: rtl/sercard_ctrl.sv
module sercard_ctrl
  import sercard_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotSelN,
  input  logic              idReqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output hostStrb_t         strb,
  output rdSel_t            rdSel,
  output logic              rdOe
);

  // Register offsets; baud and mask each occupy an even/odd pair
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_BAUD = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(10);

  logic idRead, slotRd, slotWr;
  logic rdPrev, wrPrev;
  logic rdStart, wrStart;
  logic isData, isStat, isBaud, isMask;

  // Access qualification
  always_comb begin
    idRead = !rdN && !idReqN;
    slotRd = !rdN && wrN && !slotSelN && idReqN;
    slotWr = !wrN && rdN && !slotSelN;
  end

  // Offset decode
  always_comb begin
    isData = (addr == OFS_DATA);
    isStat = (addr == OFS_STAT);
    isBaud = (addr[ADDR_W-1:1] == OFS_BAUD[ADDR_W-1:1]);
    isMask = (addr[ADDR_W-1:1] == OFS_MASK[ADDR_W-1:1]);
  end

  // Remember last cycle's access so each access starts once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= slotRd;
      wrPrev <= slotWr;
    end
  end

  always_comb begin
    rdStart = slotRd && !rdPrev;
    wrStart = slotWr && !wrPrev;
  end

  // Strobe generation
  always_comb begin
    strb          = '0;
    strb.rxTake   = rdStart && isData;
    strb.statTake = rdStart && isStat;
    strb.txLoad   = wrStart && isData;
    strb.ctrlLoad = wrStart && isStat;
    strb.baudLoad = wrStart && isBaud;
    strb.maskLoad = wrStart && isMask;
  end

  // Read source selection; identification has priority
  always_comb begin
    rdSel = RSEL_NONE;
    if (idRead)
      rdSel = RSEL_ID;
    else if (slotRd && isData)
      rdSel = RSEL_RX;
    else if (slotRd && isStat)
      rdSel = RSEL_STAT;
    rdOe = idRead || slotRd;
  end

endmodule

// File: rtl/sercard_dp.sv
module sercard_dp
  import sercard_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] ID_CODE = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  rdSel_t            rdSel,
  input  logic              rdOe,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] usartRxData,
  input  logic [DATA_W-1:0] usartStatus,
  input  logic [COND_N-1:0] cond,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output hostStrb_t         strbQ,
  output logic [DATA_W-1:0] wrDataOut,
  output logic              irqReq
);

  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  logic [COND_N-1:0] maskQ;
  logic [COND_N-1:0] gated;
  logic              anyWr;

  // Strobes leave the block registered
  always_ff @(posedge clk) begin
    if (!rstN) strbQ <= '0;
    else       strbQ <= strb;
  end

  // Write byte capture, shared by all write targets
  always_comb anyWr = strb.txLoad || strb.ctrlLoad || strb.baudLoad;

  always_ff @(posedge clk) begin
    if (!rstN)      wrDataOut <= '0;
    else if (anyWr) wrDataOut <= hostDataIn;
  end

  // Interrupt mask register
  always_ff @(posedge clk) begin
    if (!rstN)              maskQ <= '0;
    else if (strb.maskLoad) maskQ <= hostDataIn[COND_N-1:0];
  end

  // Per-condition gating
  for (genvar i = 0; i < COND_N; i++) begin : g_gate
    assign gated[i] = maskQ[i] & cond[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= |gated;
  end

  // Read multiplexer
  always_comb begin
    unique case (rdSel)
      RSEL_ID:   hostDataOut = ID_CODE;
      RSEL_RX:   hostDataOut = usartRxData;
      RSEL_STAT: hostDataOut = usartStatus;
      default:   hostDataOut = IDLE_BYTE;
    endcase
    hostDataOe = rdOe;
  end

endmodule

// File: rtl/sercard_hostif.sv
module sercard_hostif
  import sercard_pkg::*;
#(
  parameter int                ADDR_W  = 4,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] ID_CODE = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotSelN,
  input  logic              idReqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic [DATA_W-1:0] usartRxData,
  input  logic [DATA_W-1:0] usartStatus,
  input  logic              txEmpty,
  input  logic              txReady,
  input  logic              rxReady,
  input  logic              syncDet,
  output logic              usartRxTake,
  output logic              usartStatTake,
  output logic              usartTxLoad,
  output logic              usartCtrlLoad,
  output logic              baudLoad,
  output logic [DATA_W-1:0] wrDataOut,
  output logic              irqReq
);

  hostStrb_t         strb;
  hostStrb_t         strbQ;
  rdSel_t            rdSel;
  logic              rdOe;
  logic [COND_N-1:0] cond;

  // Condition bit order matches the mask bit order
  assign cond = {txEmpty, txReady, rxReady, syncDet};

  sercard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotSelN (slotSelN),
    .idReqN   (idReqN),
    .rdN      (rdN),
    .wrN      (wrN),
    .addr     (addrLo),
    .strb     (strb),
    .rdSel    (rdSel),
    .rdOe     (rdOe)
  );

  sercard_dp #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdSel       (rdSel),
    .rdOe        (rdOe),
    .hostDataIn  (hostDataIn),
    .usartRxData (usartRxData),
    .usartStatus (usartStatus),
    .cond        (cond),
    .hostDataOut (hostDataOut),
    .hostDataOe  (hostDataOe),
    .strbQ       (strbQ),
    .wrDataOut   (wrDataOut),
    .irqReq      (irqReq)
  );

  assign usartRxTake   = strbQ.rxTake;
  assign usartStatTake = strbQ.statTake;
  assign usartTxLoad   = strbQ.txLoad;
  assign usartCtrlLoad = strbQ.ctrlLoad;
  assign baudLoad      = strbQ.baudLoad;

endmodule

// File: rtl/sercard_hostif_chk.sv
module sercard_hostif_chk #(
  parameter int                ADDR_W  = 4,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] ID_CODE = 8'hF7
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotSelN,
  input logic              idReqN,
  input logic              rdN,
  input logic              wrN,
  input logic [ADDR_W-1:0] addrLo,
  input logic [DATA_W-1:0] hostDataOut,
  input logic              hostDataOe,
  input logic              txEmpty,
  input logic              txReady,
  input logic              rxReady,
  input logic              syncDet,
  input logic              usartRxTake,
  input logic              usartStatTake,
  input logic              usartTxLoad,
  input logic              usartCtrlLoad,
  input logic              baudLoad,
  input logic              irqReq
);

  logic [4:0] strbVec;
  assign strbVec = {usartRxTake, usartStatTake, usartTxLoad, usartCtrlLoad, baudLoad};

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strbVec)); // R12

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|strbVec) |=> !(|strbVec)); // R12

  AST_NO_STROBE_UNSEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|strbVec) |-> !$past(slotSelN)); // R7

  AST_ID_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (!idReqN && !rdN) |-> (hostDataOe && hostDataOut == ID_CODE)); // R8

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (slotSelN && idReqN) |-> !hostDataOe); // R7

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past({txEmpty, txReady, rxReady, syncDet} == 4'b0) |-> !irqReq); // R9

  AST_ID_NO_READ_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!idReqN && !rdN) |=> !usartRxTake && !usartStatTake); // R8

endmodule

bind sercard_hostif sercard_hostif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_CODE(ID_CODE)
) u_chk (.*);

// File: tb/tb_sercard_hostif.sv
module tb_sercard_hostif;

  logic       clk = 1'b0;
  logic       rstN;
  logic       slotSelN, idReqN, rdN, wrN;
  logic [3:0] addrLo;
  logic [7:0] hostDataIn, hostDataOut, usartRxData, usartStatus, wrDataOut;
  logic       hostDataOe;
  logic       txEmpty, txReady, rxReady, syncDet;
  logic       usartRxTake, usartStatTake, usartTxLoad, usartCtrlLoad, baudLoad;
  logic       irqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  sercard_hostif dut (.*);

  // Read vector: id, slot, offset, expected oe, data, rx strobe, status strobe
  typedef struct packed {
    logic       idN;
    logic       slotN;
    logic [3:0] ofs;
    logic       expOe;
    logic [7:0] expData;
    logic       expRx;
    logic       expStat;
  } rdVec_t;

  localparam int NV = 8;
  localparam rdVec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'h0, 1'b1, 8'h3C, 1'b1, 1'b0},  // R1
    '{1'b1, 1'b0, 4'h1, 1'b1, 8'h85, 1'b0, 1'b1},  // R2
    '{1'b1, 1'b0, 4'h2, 1'b1, 8'hFF, 1'b0, 1'b0},  // R11
    '{1'b1, 1'b0, 4'h8, 1'b1, 8'hFF, 1'b0, 1'b0},  // R11
    '{1'b1, 1'b0, 4'hF, 1'b1, 8'hFF, 1'b0, 1'b0},  // R11
    '{1'b0, 1'b1, 4'h5, 1'b1, 8'hF7, 1'b0, 1'b0},  // R8
    '{1'b0, 1'b0, 4'h0, 1'b1, 8'hF7, 1'b0, 1'b0},  // R8
    '{1'b1, 1'b1, 4'h0, 1'b0, 8'hFF, 1'b0, 1'b0}   // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] strbs();
    return {usartRxTake, usartStatTake, usartTxLoad, usartCtrlLoad, baudLoad};
  endfunction

  // Write access; expS = {tx, ctrl, baud}
  task automatic doWrite(input logic [3:0] a, input logic [7:0] d, input logic sel,
                         input logic [2:0] expS, input string tag);
    @(negedge clk);
    addrLo = a; hostDataIn = d; slotSelN = ~sel; wrN = 1'b0;
    @(negedge clk);
    chk({tag, " strobe"}, {29'd0, usartTxLoad, usartCtrlLoad, baudLoad}, {29'd0, expS});
    if (|expS) chk({tag, " data"}, {24'd0, wrDataOut}, {24'd0, d});
    @(negedge clk);
    chk({tag, " R12 held"}, {27'd0, strbs()}, 32'd0);
    wrN = 1'b1; slotSelN = 1'b1;
  endtask

  task automatic condCheck(input logic [3:0] c, input logic exp, input string tag);
    @(negedge clk);
    {txEmpty, txReady, rxReady, syncDet} = c;
    @(negedge clk);
    chk(tag, {31'd0, irqReq}, {31'd0, exp});
  endtask

  initial begin
    rstN = 1'b0; slotSelN = 1'b1; idReqN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    addrLo = '0; hostDataIn = '0; usartRxData = 8'h3C; usartStatus = 8'h85;
    {txEmpty, txReady, rxReady, syncDet} = 4'hF;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 strobes", {27'd0, strbs()}, 32'd0);
    chk("R10 irq", {31'd0, irqReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 mask clear, irq low", {31'd0, irqReq}, 32'd0);

    // Read vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idReqN = VECS[i].idN; slotSelN = VECS[i].slotN; addrLo = VECS[i].ofs; rdN = 1'b0;
      #1;
      chk($sformatf("R1/R2/R7/R8/R11 vec%0d oe", i), {31'd0, hostDataOe}, {31'd0, VECS[i].expOe});
      if (VECS[i].expOe)
        chk($sformatf("R1/R2/R8/R11 vec%0d data", i), {24'd0, hostDataOut}, {24'd0, VECS[i].expData});
      @(negedge clk);
      chk($sformatf("R1/R2 vec%0d rd strobes", i), {30'd0, usartRxTake, usartStatTake},
          {30'd0, VECS[i].expRx, VECS[i].expStat});
      @(negedge clk);
      chk($sformatf("R12 vec%0d held read", i), {27'd0, strbs()}, 32'd0);
      rdN = 1'b1; idReqN = 1'b1; slotSelN = 1'b1;
    end

    // Writes to USART targets
    doWrite(4'h0, 8'hA5, 1'b1, 3'b100, "R3 tx");
    doWrite(4'h1, 8'h5A, 1'b1, 3'b010, "R4 ctrl");
    doWrite(4'h8, 8'h0C, 1'b1, 3'b001, "R5 baud8");
    doWrite(4'h9, 8'h33, 1'b1, 3'b001, "R5 baud9");
    doWrite(4'h2, 8'h77, 1'b1, 3'b000, "R6 undecoded write");

    // Mask: bits 3 (txEmpty) and 1 (rxReady)
    doWrite(4'hA, 8'h0A, 1'b1, 3'b000, "R6 maskA");
    condCheck(4'b0100, 1'b0, "R6 txReady masked");
    condCheck(4'b0010, 1'b1, "R9 rxReady passes");
    condCheck(4'b0000, 1'b0, "R9 all clear");
    condCheck(4'b1000, 1'b1, "R9 txEmpty passes");
    condCheck(4'b0001, 1'b0, "R6 syncDet masked");

    // Deselected write must not touch the mask
    doWrite(4'hA, 8'h01, 1'b0, 3'b000, "R7 unselected write");
    condCheck(4'b0001, 1'b0, "R7 mask unchanged");
    condCheck(4'b1000, 1'b1, "R7 mask kept");

    // Offset B, upper data bits ignored: mask = 4'b0100
    doWrite(4'hB, 8'hF4, 1'b1, 3'b000, "R6 maskB");
    condCheck(4'b1011, 1'b0, "R6 upper bits ignored");
    condCheck(4'b0100, 1'b1, "R6 txReady enabled");

    // Latency of one clock
    @(negedge clk);
    {txEmpty, txReady, rxReady, syncDet} = 4'b0000;
    #1 chk("R9 before edge", {31'd0, irqReq}, 32'd1);
    @(negedge clk);
    chk("R9 after one edge", {31'd0, irqReq}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule